// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block is a direct-mapped data cache. It sits between a processor load/store port and a lower-level memory port. The cache has 64 lines of 16 bytes. Each line keeps a tag, a valid bit and a dirty bit. A 32-bit address splits into a byte offset in bits 3:0, a line index in bits 9:4 and a 22-bit tag in bits 31:10. Bits 3:2 pick one of the four 32-bit words in a line. Bits 1:0 are not used, because every access moves a whole word.

The processor raises `cpuReq` and holds the address, the write flag and the write data until `cpuReady` goes high. Two parameters set the write policy:
- `WRITE_BACK` picks write-back (1) or write-through (0) for write hits.
- `WRITE_ALLOC` picks, in write-through mode only, whether a write miss fetches the line (1) or writes around the cache (0).

The memory port uses a request/acknowledge handshake. Each transfer carries one 128-bit line aligned to 16 bytes. `memWordEn` has one bit per word and marks the words that a write updates. Word k sits in bits 32k+31:32k of `memWdata` and `memRdata`.

On a miss the processor waits. The cache first writes back a dirty victim when needed, then fetches the new line. The access then completes through the normal hit path in the cycle after the refill.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid. The first read of any address misses and starts a memory read.
- R2: The line index is address bits 9:4, the tag is bits 31:10 and the word select is bits 3:2. A memory transfer address is the line address with bits 3:0 cleared. For example, an access to 0x4BC maps to line 11 and fetches from 0x4B0.
- R3: A read hit raises `cpuReady` in the same cycle the request is presented. It returns the addressed word and makes no memory request.
- R4: On a read miss, `cpuReady` stays low while a line read runs (`memWe`=0). Once the read is acknowledged, the access completes with the addressed word of the fetched line.
- R5: In write-back mode, a write hit completes in the same cycle without memory traffic. It updates the cached word and marks the line dirty.
- R6: In write-back mode, a miss on a line that holds a dirty victim first writes the whole victim line to memory. This write uses the victim's address and `memWordEn`=4'b1111, and it finishes before the new line is read.
- R7: In write-through mode, a write hit writes the word to memory and to the cache. The memory write has `memWordEn` one-hot at bit addr[3:2] and the data in that word's lane.
- R8: In write-through mode with allocation, a write miss first fetches the line and then writes the word through. A later read of that address hits.
- R9: In write-through mode with write-around, a write miss writes only the word to memory and fetches nothing. A later read of that address misses and returns the written value.
- R10: Two addresses with the same index and different tags evict each other, so alternating accesses to them each miss.
- R11: `memReq`, `memWe` and `memAddr` stay asserted and stable from the start of a request until the cycle `memAck` is high.
- R12: In write-back mode, a write miss always fetches the line, whatever the allocation setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request, held until ready |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid when cpuReady is high on a load |
| cpuReady | output | 1 | Access completes this cycle; low means stall |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = line write, 0 = line read |
| memAddr | output | 32 | Line-aligned memory address |
| memWdata | output | 128 | Line write data |
| memWordEn | output | 4 | Word enables for a write |
| memRdata | input | 128 | Line read data, valid with memAck |
| memAck | input | 1 | One-cycle acknowledge that ends a transfer |

## Verification
The assertions assume that the processor holds `cpuAddr`, `cpuWe` and `cpuWdata` steady for as long as `cpuReq` is high and `cpuReady` is low. They also assume that memory gives exactly one acknowledge pulse per request. The bench drives each access from one task that raises the request, waits for ready and drops the request only after that edge. The memory model in the bench acknowledges each request once, after a fixed delay, and records any request that is dropped early or changes while pending.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WORD
  } ctrl_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic fillLine;    // load fetched line, tag, valid, clear dirty
    logic writeWord;   // write processor word into the indexed line
    logic markDirty;   // set dirty with writeWord
    logic cleanVictim; // victim has been written back
    logic victimAddr;  // memory address from the stored tag
    logic lineXfer;    // full-line transfer on the memory port
  } dp_strobes_t;

endpackage

// File: rtl/dm_cache_dp.sv
module dm_cache_dp
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int OFFSET_W = 4,
  parameter int INDEX_W  = 6,
  localparam int WORDS   = (8 << OFFSET_W) / WORD_W,
  localparam int LINE_W  = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  input  dp_strobes_t       strobe,
  input  logic [LINE_W-1:0] memRdata,
  output logic              lineHit,
  output logic              victimDirty,
  output logic [WORD_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LINE_W-1:0] memWdata,
  output logic [WORDS-1:0]  memWordEn
);

  localparam int LINES  = 1 << INDEX_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - OFFSET_W;
  localparam int SEL_W  = $clog2(WORDS);
  localparam int BYTE_W = OFFSET_W - SEL_W;

  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINE_W-1:0] dataArr [LINES];
  logic [LINES-1:0]  validBits;
  logic [LINES-1:0]  dirtyBits;

  logic [TAG_W-1:0]   addrTag;
  logic [INDEX_W-1:0] addrIdx;
  logic [SEL_W-1:0]   wordSel;
  logic               unusedLowBits;

  assign addrTag       = cpuAddr[ADDR_W-1 -: TAG_W];
  assign addrIdx       = cpuAddr[OFFSET_W +: INDEX_W];
  assign wordSel       = cpuAddr[BYTE_W +: SEL_W];
  assign unusedLowBits = ^cpuAddr[BYTE_W-1:0];

  assign lineHit     = validBits[addrIdx] && (tagArr[addrIdx] == addrTag);
  assign victimDirty = validBits[addrIdx] && dirtyBits[addrIdx];
  assign cpuRdata    = dataArr[addrIdx][wordSel*WORD_W +: WORD_W];

  assign memAddr   = strobe.victimAddr ? {tagArr[addrIdx], addrIdx, {OFFSET_W{1'b0}}}
                                       : {addrTag, addrIdx, {OFFSET_W{1'b0}}};
  assign memWdata  = strobe.lineXfer ? dataArr[addrIdx] : {WORDS{cpuWdata}};
  assign memWordEn = strobe.lineXfer ? {WORDS{1'b1}} : (WORDS'(1) << wordSel);

  always_ff @(posedge clk) begin
    if (strobe.fillLine) begin
      dataArr[addrIdx] <= memRdata;
      tagArr[addrIdx]  <= addrTag;
    end else if (strobe.writeWord) begin
      dataArr[addrIdx][wordSel*WORD_W +: WORD_W] <= cpuWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      dirtyBits <= '0;
    end else begin
      if (strobe.fillLine) begin
        validBits[addrIdx] <= 1'b1;
        dirtyBits[addrIdx] <= 1'b0;
      end else if (strobe.writeWord && strobe.markDirty) begin
        dirtyBits[addrIdx] <= 1'b1;
      end else if (strobe.cleanVictim) begin
        dirtyBits[addrIdx] <= 1'b0;
      end
    end
  end

  // R4
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillLine |=> lineHit)
    else $error("refilled line does not hit");

endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
#(
  parameter int WRITE_BACK  = 1,
  parameter int WRITE_ALLOC = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        lineHit,
  input  logic        victimDirty,
  input  logic        memAck,
  output logic        cpuReady,
  output logic        memReq,
  output logic        memWe,
  output dp_strobes_t strobe
);

  localparam bit IS_WB  = (WRITE_BACK != 0);
  localparam bit AROUND = !IS_WB && (WRITE_ALLOC == 0);

  ctrl_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (lineHit) begin
            if (!cpuWe) begin
              cpuReady = 1'b1;
            end else if (IS_WB) begin
              cpuReady         = 1'b1;
              strobe.writeWord = 1'b1;
              strobe.markDirty = 1'b1;
            end else begin
              stateNext = ST_WORD;
            end
          end else if (IS_WB && victimDirty) begin
            stateNext = ST_EVICT;
          end else if (cpuWe && AROUND) begin
            stateNext = ST_WORD;
          end else begin
            stateNext = ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        memReq            = 1'b1;
        memWe             = 1'b1;
        strobe.victimAddr = 1'b1;
        strobe.lineXfer   = 1'b1;
        if (memAck) begin
          strobe.cleanVictim = 1'b1;
          stateNext          = ST_FILL;
        end
      end
      ST_FILL: begin
        memReq          = 1'b1;
        strobe.lineXfer = 1'b1;
        if (memAck) begin
          strobe.fillLine = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      ST_WORD: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          cpuReady         = 1'b1;
          strobe.writeWord = lineHit;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && memWe == $past(memWe)))
    else $error("memory request dropped or changed before ack");

  // R6
  no_fill_over_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> !victimDirty)
    else $error("line read started while the victim is dirty");

endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int OFFSET_W    = 4,
  parameter int INDEX_W     = 6,
  parameter int WRITE_BACK  = 1,
  parameter int WRITE_ALLOC = 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cpuReq,
  input  logic                                cpuWe,
  input  logic [ADDR_W-1:0]                   cpuAddr,
  input  logic [WORD_W-1:0]                   cpuWdata,
  output logic [WORD_W-1:0]                   cpuRdata,
  output logic                                cpuReady,
  output logic                                memReq,
  output logic                                memWe,
  output logic [ADDR_W-1:0]                   memAddr,
  output logic [(8<<OFFSET_W)-1:0]            memWdata,
  output logic [((8<<OFFSET_W)/WORD_W)-1:0]   memWordEn,
  input  logic [(8<<OFFSET_W)-1:0]            memRdata,
  input  logic                                memAck
);

  dp_strobes_t strobe;
  logic        lineHit;
  logic        victimDirty;

  dm_cache_ctrl #(
    .WRITE_BACK  (WRITE_BACK),
    .WRITE_ALLOC (WRITE_ALLOC)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReq      (cpuReq),
    .cpuWe       (cpuWe),
    .lineHit     (lineHit),
    .victimDirty (victimDirty),
    .memAck      (memAck),
    .cpuReady    (cpuReady),
    .memReq      (memReq),
    .memWe       (memWe),
    .strobe      (strobe)
  );

  dm_cache_dp #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .OFFSET_W (OFFSET_W),
    .INDEX_W  (INDEX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .strobe      (strobe),
    .memRdata    (memRdata),
    .lineHit     (lineHit),
    .victimDirty (victimDirty),
    .cpuRdata    (cpuRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memWordEn   (memWordEn)
  );

  // R11
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr))
    else $error("memory address moved while a request is pending");

  if (WRITE_BACK != 0) begin : g_wbChk
    // R6
    wb_full_line_chk: assert property (@(posedge clk) disable iff (!rstN)
      (memReq && memWe) |-> (&memWordEn))
      else $error("write-back mode issued a partial line write");
  end else begin : g_wtChk
    // R7
    wt_one_word_chk: assert property (@(posedge clk) disable iff (!rstN)
      (memReq && memWe) |-> ($countones(memWordEn) == 1))
      else $error("write-through mode wrote other than one word");
  end

endmodule

// File: tb/dm_cache_bench.sv
`timescale 1ns/1ps

module dm_cache_mem_model (
  input  logic         clk,
  input  logic         rstN,
  input  logic         memReq,
  input  logic         memWe,
  input  logic [31:0]  memAddr,
  input  logic [127:0] memWdata,
  input  logic [3:0]   memWordEn,
  output logic [127:0] memRdata,
  output logic         memAck,
  output logic [31:0]  rdCnt,
  output logic [31:0]  wrCnt,
  output logic [31:0]  lastRdAddr,
  output logic [31:0]  lastWrAddr,
  output logic [127:0] lastWrData,
  output logic [3:0]   lastWrEn,
  output logic [31:0]  lastRdSeq,
  output logic [31:0]  lastWrSeq,
  output logic         protoErr
);
  logic [127:0] store [1024];
  logic [31:0]  seq;
  logic [31:0]  pendAddr;
  logic         pendWe;
  int           cnt;

  initial begin
    for (int i = 0; i < 1024; i++)
      for (int w = 0; w < 4; w++)
        store[i][w*32 +: 32] = 32'hC000_0000 | (i << 2) | w;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 0; cnt <= 0; seq <= 0; rdCnt <= 0; wrCnt <= 0;
      protoErr <= 0; memRdata <= '0; lastRdSeq <= 0; lastWrSeq <= 0;
      lastRdAddr <= 0; lastWrAddr <= 0; lastWrData <= '0; lastWrEn <= 0;
      pendAddr <= 0; pendWe <= 0;
    end else if (memAck) begin
      memAck <= 0;
      cnt    <= 0;
    end else if (memReq) begin
      if (cnt > 0 && (memAddr != pendAddr || memWe != pendWe)) protoErr <= 1;
      pendAddr <= memAddr;
      pendWe   <= memWe;
      cnt      <= cnt + 1;
      if (cnt == 2) begin
        memAck <= 1;
        seq    <= seq + 1;
        if (memWe) begin
          for (int w = 0; w < 4; w++)
            if (memWordEn[w]) store[memAddr[13:4]][w*32 +: 32] <= memWdata[w*32 +: 32];
          wrCnt      <= wrCnt + 1;
          lastWrAddr <= memAddr;
          lastWrData <= memWdata;
          lastWrEn   <= memWordEn;
          lastWrSeq  <= seq + 1;
        end else begin
          memRdata   <= store[memAddr[13:4]];
          rdCnt      <= rdCnt + 1;
          lastRdAddr <= memAddr;
          lastRdSeq  <= seq + 1;
        end
      end
    end else if (cnt > 0) begin
      protoErr <= 1;
    end
  end
endmodule

module dm_cache_bench;
  logic clk = 0;
  logic rstN = 0;
  always #4 clk = ~clk;

  // unit 0: write-back, unit 1: write-through allocate, unit 2: write-through around
  logic         cpuReq   [3];
  logic         cpuWe    [3];
  logic [31:0]  cpuAddr  [3];
  logic [31:0]  cpuWdata [3];
  logic [31:0]  cpuRdata [3];
  logic         cpuReady [3];
  logic         memReq   [3];
  logic         memWe    [3];
  logic [31:0]  memAddr  [3];
  logic [127:0] memWdata [3];
  logic [3:0]   memWordEn[3];
  logic [127:0] memRdata [3];
  logic         memAck   [3];
  logic [31:0]  rdCnt [3], wrCnt [3], lastRdAddr [3], lastWrAddr [3];
  logic [31:0]  lastRdSeq [3], lastWrSeq [3];
  logic [127:0] lastWrData [3];
  logic [3:0]   lastWrEn [3];
  logic         protoErr [3];

  for (genvar g = 0; g < 3; g++) begin : g_unit
    dm_cache #(
      .WRITE_BACK  (g == 0 ? 1 : 0),
      .WRITE_ALLOC (g == 2 ? 0 : 1)
    ) u_dm_cache (
      .clk(clk), .rstN(rstN),
      .cpuReq(cpuReq[g]), .cpuWe(cpuWe[g]), .cpuAddr(cpuAddr[g]),
      .cpuWdata(cpuWdata[g]), .cpuRdata(cpuRdata[g]), .cpuReady(cpuReady[g]),
      .memReq(memReq[g]), .memWe(memWe[g]), .memAddr(memAddr[g]),
      .memWdata(memWdata[g]), .memWordEn(memWordEn[g]),
      .memRdata(memRdata[g]), .memAck(memAck[g])
    );
    dm_cache_mem_model u_mem (
      .clk(clk), .rstN(rstN),
      .memReq(memReq[g]), .memWe(memWe[g]), .memAddr(memAddr[g]),
      .memWdata(memWdata[g]), .memWordEn(memWordEn[g]),
      .memRdata(memRdata[g]), .memAck(memAck[g]),
      .rdCnt(rdCnt[g]), .wrCnt(wrCnt[g]), .lastRdAddr(lastRdAddr[g]),
      .lastWrAddr(lastWrAddr[g]), .lastWrData(lastWrData[g]), .lastWrEn(lastWrEn[g]),
      .lastRdSeq(lastRdSeq[g]), .lastWrSeq(lastWrSeq[g]), .protoErr(protoErr[g])
    );
  end

  int checks = 0;
  int fails  = 0;

  localparam logic [31:0] ADDR_A = 32'h0000_04B0; // line 11, tag 1
  localparam logic [31:0] ADDR_B = 32'h0000_08B0; // line 11, tag 2
  localparam logic [31:0] ADDR_C = 32'h0000_01C4; // line 28, word 1
  localparam logic [31:0] ADDR_D = 32'h0000_02C8; // line 44, word 2

  function automatic logic [31:0] initWord(logic [31:0] a);
    return 32'hC000_0000 | {18'b0, a[13:2]};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(int u, bit we, logic [31:0] a, logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    cpuReq[u] = 1; cpuWe[u] = we; cpuAddr[u] = a; cpuWdata[u] = wd;
    stalls = 0;
    #1;
    while (!cpuReady[u] && stalls < 200) begin
      @(negedge clk); #1; stalls++;
    end
    rd = cpuRdata[u];
    @(posedge clk); #1;
    cpuReq[u] = 0; cpuWe[u] = 0;
  endtask

  task automatic t_reset();
    for (int u = 0; u < 3; u++) begin
      check("R1 memReq idle after reset", 128'(memReq[u]), 128'd0);
      check("R1 cpuReady low with no request", 128'(cpuReady[u]), 128'd0);
    end
  endtask

  task automatic t_read_miss_hit();
    logic [31:0] rd; int st; logic [31:0] r0;
    r0 = rdCnt[0];
    access(0, 0, ADDR_A + 32'hC, 0, rd, st);
    check("R1 first read stalls", 128'(st > 0), 128'd1);
    check("R4 miss returns fetched word", 128'(rd), 128'(initWord(ADDR_A + 32'hC)));
    check("R4 one line read", 128'(rdCnt[0] - r0), 128'd1);
    check("R2 line-aligned fetch of line 11", 128'(lastRdAddr[0]), 128'(ADDR_A));
    r0 = rdCnt[0];
    access(0, 0, ADDR_A + 32'h4, 0, rd, st);
    check("R3 read hit no stall", 128'(st), 128'd0);
    check("R3 read hit data", 128'(rd), 128'(initWord(ADDR_A + 32'h4)));
    check("R3 read hit no memory read", 128'(rdCnt[0] - r0), 128'd0);
  endtask

  task automatic t_wb_write_hit();
    logic [31:0] rd; int st; logic [31:0] r0, w0;
    r0 = rdCnt[0]; w0 = wrCnt[0];
    access(0, 1, ADDR_A + 32'h8, 32'hDEAD_BEEF, rd, st);
    check("R5 write hit no stall", 128'(st), 128'd0);
    check("R5 write hit no memory traffic", 128'((rdCnt[0] - r0) + (wrCnt[0] - w0)), 128'd0);
    access(0, 0, ADDR_A + 32'h8, 0, rd, st);
    check("R5 cached word updated", 128'(rd), 128'h0DEAD_BEEF);
    check("R5 read back hits", 128'(st), 128'd0);
  endtask

  task automatic t_wb_evict();
    logic [31:0] rd; int st; logic [31:0] r0, w0;
    r0 = rdCnt[0]; w0 = wrCnt[0];
    access(0, 0, ADDR_B, 0, rd, st);
    check("R6 victim written once", 128'(wrCnt[0] - w0), 128'd1);
    check("R6 victim address", 128'(lastWrAddr[0]), 128'(ADDR_A));
    check("R6 full-line enables", 128'(lastWrEn[0]), 128'hF);
    check("R6 dirty word in victim data", 128'(lastWrData[0][95:64]), 128'hDEAD_BEEF);
    check("R6 write before read", 128'(lastWrSeq[0] < lastRdSeq[0]), 128'd1);
    check("R10 conflicting line fetched", 128'(rd), 128'(initWord(ADDR_B)));
    r0 = rdCnt[0]; w0 = wrCnt[0];
    access(0, 0, ADDR_A + 32'h8, 0, rd, st);
    check("R10 evicted line misses again", 128'(rdCnt[0] - r0), 128'd1);
    check("R6 clean victim not written", 128'(wrCnt[0] - w0), 128'd0);
    check("R6 written-back data from memory", 128'(rd), 128'h0DEAD_BEEF);
  endtask

  task automatic t_wb_write_miss();
    logic [31:0] rd; int st; logic [31:0] r0;
    r0 = rdCnt[0];
    access(0, 1, ADDR_D, 32'h5555_AAAA, rd, st);
    check("R12 write-back write miss fetches", 128'(rdCnt[0] - r0), 128'd1);
    access(0, 0, ADDR_D, 0, rd, st);
    check("R12 allocated line hits", 128'(st), 128'd0);
    check("R12 stored value", 128'(rd), 128'h5555_AAAA);
  endtask

  task automatic t_wt_write_hit();
    logic [31:0] rd; int st; logic [31:0] w0;
    access(1, 0, ADDR_A, 0, rd, st);
    w0 = wrCnt[1];
    access(1, 1, ADDR_A + 32'h4, 32'h1234_5678, rd, st);
    check("R7 one word write", 128'(wrCnt[1] - w0), 128'd1);
    check("R7 word enable bit 1", 128'(lastWrEn[1]), 128'h2);
    check("R7 aligned address", 128'(lastWrAddr[1]), 128'(ADDR_A));
    check("R7 data in lane 1", 128'(lastWrData[1][63:32]), 128'h1234_5678);
    access(1, 0, ADDR_A + 32'h4, 0, rd, st);
    check("R7 cache updated too", 128'(rd), 128'h1234_5678);
    check("R7 read back hits", 128'(st), 128'd0);
  endtask

  task automatic t_wt_alloc();
    logic [31:0] rd; int st; logic [31:0] r0, w0;
    r0 = rdCnt[1]; w0 = wrCnt[1];
    access(1, 1, ADDR_C, 32'hCAFE_0001, rd, st);
    check("R8 fetch on write miss", 128'(rdCnt[1] - r0), 128'd1);
    check("R8 word written through", 128'(wrCnt[1] - w0), 128'd1);
    check("R8 fetch before write", 128'(lastRdSeq[1] < lastWrSeq[1]), 128'd1);
    access(1, 0, ADDR_C, 0, rd, st);
    check("R8 later read hits", 128'(st), 128'd0);
    check("R8 later read data", 128'(rd), 128'hCAFE_0001);
  endtask

  task automatic t_wt_around();
    logic [31:0] rd; int st; logic [31:0] r0, w0;
    r0 = rdCnt[2]; w0 = wrCnt[2];
    access(2, 1, ADDR_C, 32'hBEEF_0002, rd, st);
    check("R9 no fetch", 128'(rdCnt[2] - r0), 128'd0);
    check("R9 word written", 128'(wrCnt[2] - w0), 128'd1);
    check("R9 word enable bit 1", 128'(lastWrEn[2]), 128'h2);
    r0 = rdCnt[2];
    access(2, 0, ADDR_C, 0, rd, st);
    check("R9 later read misses", 128'(rdCnt[2] - r0), 128'd1);
    check("R9 value from memory", 128'(rd), 128'hBEEF_0002);
  endtask

  task automatic t_conflict();
    logic [31:0] rd; int st; logic [31:0] r0;
    r0 = rdCnt[1];
    access(1, 0, ADDR_B, 0, rd, st);
    access(1, 0, ADDR_A, 0, rd, st);
    check("R10 returning line refetched", 128'(rd), 128'(initWord(ADDR_A)));
    access(1, 0, ADDR_B + 32'h4, 0, rd, st);
    check("R10 three alternating misses", 128'(rdCnt[1] - r0), 128'd3);
    check("R10 conflict data", 128'(rd), 128'(initWord(ADDR_B + 32'h4)));
  endtask

  task automatic finish_run();
    for (int u = 0; u < 3; u++)
      check("R11 handshake held until ack", 128'(protoErr[u]), 128'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int u = 0; u < 3; u++) begin
      cpuReq[u] = 0; cpuWe[u] = 0; cpuAddr[u] = 0; cpuWdata[u] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    t_reset();
    t_read_miss_hit();
    t_wb_write_hit();
    t_wb_evict();
    t_wb_write_miss();
    t_wt_write_hit();
    t_wt_alloc();
    t_wt_around();
    t_conflict();
    finish_run();
  end
endmodule